// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This block sits on the slave side of a two-wire serial bus and decides whether the first byte after each START names this device. It resynchronises the clock and data lines to the system clock, spots START, repeated START and STOP, shifts in the address byte and compares it with a host-programmed own address. Two comparison modes exist. The short mode compares seven bits and ignores the direction bit. The extended mode is the first stage of 10-bit addressing and treats the direction bit as part of the address, matching it against a stored bit that the host controls.

On a match the block raises an addressed flag and pulls the data line low for the acknowledge clock. In extended mode, when the matched byte carried a write direction, the following byte is shifted in and presented to the host with a one-cycle strobe. The host checks that second address byte itself. Once satisfied, it sets the stored direction bit to 1, so that the read-direction first byte sent after a repeated START also matches. Host configuration uses a single write strobe that loads the address, the stored direction bit and the mode together. A write takes effect from the next clock. A comparison in the same cycle as a write uses the earlier contents.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the addressed flag is 0, the data line is released (`sda_pull` = 0), `byte2_valid` is 0, and the mode bit, stored direction bit and address are all 0.
- R2: With mode bit 0 (7-bit mode), a first byte whose upper seven bits equal the programmed address matches whatever its last bit is: the flag becomes 1 and the block acknowledges.
- R3: In 7-bit mode, a first byte whose upper seven bits differ from the address gets no acknowledge and leaves the flag at 0.
- R4: With mode bit 1 (10-bit mode), all eight bits are compared with {address, stored direction bit}, so a byte whose last bit differs from the stored bit does not match.
- R5: In 10-bit mode, a byte equal to {address, stored direction bit} sets the flag and is acknowledged.
- R6: In 10-bit mode, after a matched byte whose last bit is 0, the next eight bits appear MSB first on `rx_byte` with `byte2_valid` high for exactly one cycle. The block does not acknowledge that byte.
- R7: Once the host has set the stored direction bit to 1, a byte {address, 1} after a repeated START matches. A host write in the same cycle as a comparison does not affect that comparison.
- R8: A STOP (data rising while the clock is high) clears the flag.
- R9: A START whose address byte does not match clears the flag when that byte completes.
- R10: `sda_pull` rises only while the clock line is low after the eighth bit, stays high through the ninth clock, and is released after the ninth clock falls.
- R11: A START or repeated START in the middle of a byte discards the partial bits, releases the data line and restarts address capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as sensed |
| sda_in | input | 1 | Bus data line as sensed |
| sda_pull | output | 1 | 1 pulls the data line low (acknowledge) |
| cfg_we | input | 1 | Load strobe for the three configuration fields |
| cfg_addr | input | 7 | Own 7-bit address |
| cfg_rw | input | 1 | Stored direction bit |
| cfg_mode10 | input | 1 | 0 = 7-bit mode, 1 = 10-bit mode |
| aas | output | 1 | Addressed-as-slave flag |
| rx_byte | output | 8 | Second address byte for host comparison |
| byte2_valid | output | 1 | One-cycle strobe when `rx_byte` is fresh |

## Verification
A host write of the stored direction bit can land in the same clock as the hardware comparison of the eighth address bit. The bench provokes this by counting the synchroniser delay after it raises the eighth clock, then pulsing the write on exactly the cycle in which the design evaluates the byte. The byte is judged against the value held before the write, so a read-direction byte sent with the bit still 0 must be refused. A repeated START that follows must then match with the new bit. Random addresses, modes and bytes are also compared against a bench model of the matching rule.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACKW,
        ST_ACK,
        ST_RX2,
        ST_WAIT
    } am_state_e;

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_am_events.sv
module i2c_am_events (
    input  logic clk,
    input  logic rst_n,
    input  logic s_scl,
    input  logic s_sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= s_scl;
            sda_q <= s_sda;
        end
    end

    always_comb begin
        scl_rise = s_scl & ~scl_q;
        scl_fall = ~s_scl & scl_q;
        ev_start = s_scl & scl_q & sda_q & ~s_sda;
        ev_stop  = s_scl & scl_q & ~sda_q & s_sda;
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_rw,
    input  logic              cfg_mode10,
    output logic              aas,
    output logic [ADDR_W:0]   rx_byte,
    output logic              byte2_valid
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        am_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] rx;
        logic              aas;
        logic              pull;
        logic              b2v;
        logic              dir;
        logic              rwb;
        logic              mode10;
        logic [ADDR_W-1:0] addr;
    } regs_t;

    logic s_scl, s_sda;
    logic scl_rise, scl_fall, ev_start, ev_stop;
    regs_t r_q, r_d;
    logic last_bit, hit;
    logic [BYTE_W-1:0] byte_now;

    i2c_am_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_in, sda_in}),
        .q    ({s_scl, s_sda})
    );

    i2c_am_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_scl   (s_scl),
        .s_sda   (s_sda),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .ev_start(ev_start),
        .ev_stop (ev_stop)
    );

    always_comb begin
        byte_now = {r_q.sh[BYTE_W-2:0], s_sda};
        last_bit = (r_q.cnt == CNT_W'(BYTE_W - 1));
        if (r_q.mode10) hit = (byte_now == {r_q.addr, r_q.rwb});
        else            hit = (r_q.sh[BYTE_W-2:0] == r_q.addr);
    end

    always_comb begin
        r_d     = r_q;
        r_d.b2v = 1'b0;
        if (cfg_we) begin
            r_d.addr   = cfg_addr;
            r_d.rwb    = cfg_rw;
            r_d.mode10 = cfg_mode10;
        end
        if (ev_stop) begin
            r_d.st   = ST_IDLE;
            r_d.aas  = 1'b0;
            r_d.pull = 1'b0;
        end else if (ev_start) begin
            r_d.st   = ST_ADDR;
            r_d.cnt  = '0;
            r_d.pull = 1'b0;
        end else begin
            case (r_q.st)
                ST_ADDR: if (scl_rise) begin
                    r_d.sh  = byte_now;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (last_bit) begin
                        r_d.aas = hit;
                        r_d.dir = s_sda;
                        r_d.st  = hit ? ST_ACKW : ST_WAIT;
                    end
                end
                ST_ACKW: if (scl_fall) begin
                    r_d.pull = 1'b1;
                    r_d.st   = ST_ACK;
                end
                ST_ACK: if (scl_fall) begin
                    r_d.pull = 1'b0;
                    r_d.cnt  = '0;
                    r_d.st   = (r_q.mode10 && !r_q.dir) ? ST_RX2 : ST_WAIT;
                end
                ST_RX2: if (scl_rise) begin
                    r_d.sh  = byte_now;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (last_bit) begin
                        r_d.rx  = byte_now;
                        r_d.b2v = 1'b1;
                        r_d.st  = ST_WAIT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull    = r_q.pull;
    assign aas         = r_q.aas;
    assign rx_byte     = r_q.rx;
    assign byte2_valid = r_q.b2v;

    a_r8_stop_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !aas);
    a_r11_start_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> !sda_pull);
    a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        byte2_valid |=> !byte2_valid);
    a_r10_pull_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !s_scl);
    a_r10_pull_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> aas);
endmodule

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
    localparam int H = 10;

    logic clk = 0, rst_n = 0;
    logic scl_m = 1, sda_m = 1;
    logic cfg_we = 0, cfg_rw = 0, cfg_mode10 = 0;
    logic [6:0] cfg_addr = '0;
    logic sda_pull, aas, byte2_valid;
    logic [7:0] rx_byte;
    logic sda_line;
    int checks = 0, fails = 0, b2_cnt = 0;
    logic [7:0] b2_val = '0;
    logic done = 0;
    logic ack, pre_pull;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    i2c_addr_match dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_rw(cfg_rw), .cfg_mode10(cfg_mode10), .aas(aas),
        .rx_byte(rx_byte), .byte2_valid(byte2_valid)
    );

    always @(negedge clk) if (byte2_valid) begin
        b2_cnt++;
        b2_val = rx_byte;
    end

    function automatic bit exp_hit(bit m10, logic [6:0] a, bit rw, logic [7:0] b);
        return m10 ? (b == {a, rw}) : (b[7:1] == a);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(logic [6:0] a, bit rw, bit m);
        cfg_addr = a; cfg_rw = rw; cfg_mode10 = m; cfg_we = 1;
        w(1);
        cfg_we = 0;
        w(1);
    endtask

    task automatic start_c();
        sda_m = 1; w(H); scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0; w(H);
    endtask

    task automatic stop_c();
        sda_m = 0; w(H); scl_m = 1; w(H); sda_m = 1; w(H);
    endtask

    // coinc: pulse a write of stored bit 1 in the cycle the eighth bit is judged
    task automatic send_byte(logic [7:0] b, bit coinc, output logic acked, output logic pre);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(H); scl_m = 1;
            if (i == 0 && coinc) begin
                w(2); cfg_rw = 1; cfg_we = 1; w(1); cfg_we = 0; w(H - 3);
            end else w(H);
            if (i == 0) pre = sda_pull;
            scl_m = 0;
        end
        sda_m = 1; w(H); scl_m = 1; w(H / 2);
        acked = sda_pull;
        w(H / 2); scl_m = 0; w(H);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n0;
        logic [6:0] ra;
        logic [7:0] rb;
        bit rm, rrw, e;
        void'($urandom(32'h5eed));
        w(3);
        chk(aas == 0 && sda_pull == 0 && byte2_valid == 0, "R1", {aas, sda_pull, byte2_valid}, 0);
        rst_n = 1; w(3);
        // R1: defaults mean 7-bit mode, address 0
        start_c(); send_byte(8'h01, 0, ack, pre_pull);
        chk(ack == 1 && aas == 1, "R1", {ack, aas}, 3);
        stop_c(); w(4);
        chk(aas == 0, "R8", aas, 0);

        cfg(7'h3A, 0, 0);
        start_c(); send_byte({7'h3A, 1'b0}, 0, ack, pre_pull);
        chk(ack == 1 && aas == 1, "R2", {ack, aas}, 3);
        chk(pre_pull == 0, "R10", pre_pull, 0);
        w(2);
        chk(sda_pull == 0, "R10", sda_pull, 0);
        stop_c(); w(4);
        chk(aas == 0, "R8", aas, 0);
        start_c(); send_byte({7'h3A, 1'b1}, 0, ack, pre_pull);
        chk(ack == 1 && aas == 1, "R2", {ack, aas}, 3);
        stop_c();
        start_c(); send_byte({7'h3B, 1'b0}, 0, ack, pre_pull);
        chk(ack == 0 && aas == 0, "R3", {ack, aas}, 0);
        stop_c();

        cfg(7'h7A, 0, 1);
        start_c(); send_byte({7'h7A, 1'b0}, 0, ack, pre_pull);
        chk(ack == 1 && aas == 1, "R5", {ack, aas}, 3);
        n0 = b2_cnt;
        send_byte(8'hC5, 0, ack, pre_pull);
        chk(b2_cnt == n0 + 1 && b2_val == 8'hC5, "R6", b2_val, 8'hC5);
        chk(ack == 0, "R6", ack, 0);
        start_c(); send_byte({7'h7A, 1'b1}, 0, ack, pre_pull);
        chk(ack == 0 && aas == 0, "R4", {ack, aas}, 0);
        chk(aas == 0, "R9", aas, 0);
        start_c(); send_byte({7'h7A, 1'b0}, 0, ack, pre_pull);
        send_byte(8'h5C, 0, ack, pre_pull);
        cfg(7'h7A, 1, 1);
        start_c(); send_byte({7'h7A, 1'b1}, 0, ack, pre_pull);
        chk(ack == 1 && aas == 1, "R7", {ack, aas}, 3);
        stop_c();
        start_c(); send_byte({7'h7A, 1'b0}, 0, ack, pre_pull);
        chk(ack == 0 && aas == 0, "R4", {ack, aas}, 0);
        stop_c();

        // R11: repeated START after four bits restarts capture
        cfg(7'h15, 0, 0);
        start_c();
        for (int i = 0; i < 4; i++) begin
            sda_m = i[0]; w(H); scl_m = 1; w(H); scl_m = 0;
        end
        start_c(); send_byte({7'h15, 1'b0}, 0, ack, pre_pull);
        chk(ack == 1 && aas == 1, "R11", {ack, aas}, 3);
        // R9: flag drops once a mismatching byte completes after repeated START
        start_c(); send_byte(8'hFF, 0, ack, pre_pull);
        chk(aas == 0, "R9", aas, 0);
        stop_c();

        // R7: write coinciding with the comparison does not affect it
        cfg(7'h66, 0, 1);
        start_c(); send_byte({7'h66, 1'b1}, 1, ack, pre_pull);
        chk(ack == 0 && aas == 0, "R7", {ack, aas}, 0);
        start_c(); send_byte({7'h66, 1'b1}, 0, ack, pre_pull);
        chk(ack == 1 && aas == 1, "R7", {ack, aas}, 3);
        stop_c();

        for (int k = 0; k < 40; k++) begin
            ra = 7'($urandom); rm = 1'($urandom); rrw = 1'($urandom);
            rb = ($urandom % 2) ? {ra, 1'($urandom)} : 8'($urandom);
            cfg(ra, rrw, rm);
            e = exp_hit(rm, ra, rrw, rb);
            start_c(); send_byte(rb, 0, ack, pre_pull);
            chk(ack == e && aas == e, rm ? "R4" : "R2", {ack, aas}, {e, e});
            stop_c(); w(4);
            chk(aas == 0, "R8", aas, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule